// File: doc/BRIEF.md
# Card Attribute Configuration Registers

This block answers the attribute-memory space of a removable storage card on a plain byte-wide register bus: address, write enable, write data and a combinational read-data path. Addresses below a configuration base return bytes from a card information table held in a parameter ROM, and addresses past the end of that table read as zero. At and above the base sit four byte registers. The option register sets the addressing mode, level interrupts and a soft-reset hold. The card status register holds the power-down flag, several host-writable flags and the drive interrupt level. The pin register holds the card-ready and memory-ready bits. The socket register always reads as zero.

The block also drives the host interrupt line. That line combines the drive's interrupt level in inverted sense with two device-control bits and the soft-reset hold. The device-control byte comes from the task-file decoder on its own input port. The configuration state is brought out on plain outputs so that the card's address decoder and the drive can follow it.

Top module: `pccfg_bank`

## Requirements
- R1: After reset, the option, status and pin registers are zero. This selects memory-mapped mode (card_mode = 0). A status read gives 0x00, a pin read gives 0x0C, and card_ready, mem_ready, power_down, level_irq and card_reset are low.
- R2: A read at an address below CFG_BASE (0x200) returns table byte number `addr` when `addr` < TBL_LEN. Otherwise it returns 0x00.
- R3: A write at offset 0 stores `wr_data & 0xCF` in the option register, which reads back unchanged. card_mode shows bits 5:0 and level_irq shows bit 6.
- R4: A write at offset 2 keeps status bits 7 and 1 and loads bits 6, 5, 4 and 2 from `wr_data`. power_down shows status bit 2.
- R5: A status write whose bit 2 differs from the current power-down bit sets card-ready (pin bit 5). That bit then stays set until reset or soft-reset hold.
- R6: A status read returns the register with bit 1 forced to zero while device-control bit 1 is set.
- R7: A pin read returns `(pins & 0x20) | 0x0C`. A pin write keeps bit 5 and loads only bit 1, which appears on mem_ready.
- R8: Offset 6 reads as 0x00, and writes to it change no state.
- R9: host_line is high only when status bit 1 is clear, device-control bits 1 and 2 are both clear, and option bit 7 is clear.
- R10: When no soft-reset hold is in effect, status bit 1 takes the level of drive_irq at each clock edge. It is visible one cycle later.
- R11: Writes to an offset other than 0, 2, 4 or 6 at or above the base, and writes below the base, change nothing. Reads of such offsets at or above the base return 0x00.
- R12: While option bit 7 is set, the status and pin registers are held at zero and card_reset is high. The other option bits keep their written values, and writing option bit 7 low releases the hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address in attribute space |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte for the current address (combinational) |
| drive_irq | input | 1 | Interrupt level from the drive |
| devctl | input | 8 | Device-control byte from the task-file decoder |
| host_line | output | 1 | Host interrupt line level |
| card_mode | output | 6 | Addressing-mode field of the option register |
| level_irq | output | 1 | Level-interrupt select from the option register |
| card_reset | output | 1 | Soft-reset hold is active |
| power_down | output | 1 | Power-down flag from the status register |
| card_ready | output | 1 | Card-ready bit of the pin register |
| mem_ready | output | 1 | Memory-ready bit of the pin register |

## Verification
The bench targets the masked merges.

- If the status keep mask is wrong, either bit 1 stops following drive_irq or the written flags appear in the wrong place.
- If the option mask is wrong, bits 5 and 4 are stored, and both the mode field and the read-back change.
- If the power-down comparison uses the new value instead of the difference between old and new, card_ready is set on a write that leaves the flag unchanged.

Several other paths are also covered, each with a visible failure:

- Status reads with the interrupt-enable bit set: a design that fails to hide bit 1 shows the interrupt.
- Each interrupt gate on its own: a missing gate leaves host_line high.
- Soft-reset hold: a design that clears the register only once, instead of holding it, lets status writes leak through during the hold.
- Writes to the socket register, to unknown offsets and to table addresses: a decoder that aliases any of these corrupts a register.

// File: rtl/pccfg_pkg.sv
package pccfg_pkg;

  // which register a bus address reaches
  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_TABLE = 3'd1,
    SEL_OPT   = 3'd2,
    SEL_STAT  = 3'd3,
    SEL_PINS  = 3'd4,
    SEL_SOCK  = 3'd5
  } reg_sel_e;

  localparam logic [7:0] OPT_STORE_MASK  = 8'hCF;
  localparam logic [7:0] STAT_KEEP_MASK  = 8'h82;
  localparam logic [7:0] STAT_LOAD_MASK  = 8'h74;
  localparam logic [7:0] PINS_KEEP_MASK  = 8'h20;
  localparam logic [7:0] PINS_LOAD_MASK  = 8'h02;
  localparam logic [7:0] PINS_READ_FIXED = 8'h0C;

  localparam int OPT_HOLD_BIT = 7;
  localparam int STAT_IRQ_BIT = 1;
  localparam int STAT_PWR_BIT = 2;
  localparam int PINS_RDY_BIT = 5;
  localparam int PINS_MRD_BIT = 1;
  localparam int DC_IEN_BIT   = 1;
  localparam int DC_SRST_BIT  = 2;

  function automatic logic [7:0] opt_store(input logic [7:0] v);
    return v & OPT_STORE_MASK;
  endfunction

  // status write: keep flags under the keep mask, take the rest from v
  function automatic logic [7:0] stat_merge(input logic [7:0] old_v,
                                            input logic [7:0] v);
    return (old_v & STAT_KEEP_MASK) | (v & STAT_LOAD_MASK);
  endfunction

  function automatic logic pwr_flip(input logic [7:0] old_v,
                                    input logic [7:0] v);
    return old_v[STAT_PWR_BIT] ^ v[STAT_PWR_BIT];
  endfunction

  function automatic logic [7:0] pins_merge(input logic [7:0] old_v,
                                            input logic [7:0] v);
    return (old_v & PINS_KEEP_MASK) | (v & PINS_LOAD_MASK);
  endfunction

  function automatic logic [7:0] stat_view(input logic [7:0] st,
                                           input logic [7:0] dc);
    logic [7:0] r;
    r = st;
    if (dc[DC_IEN_BIT]) r[STAT_IRQ_BIT] = 1'b0;
    return r;
  endfunction

  function automatic logic [7:0] pins_view(input logic [7:0] p);
    return (p & PINS_KEEP_MASK) | PINS_READ_FIXED;
  endfunction

  // inverted-sense interrupt combined with three gates
  function automatic logic line_level(input logic st_irq,
                                      input logic [7:0] dc,
                                      input logic hold);
    return !st_irq && !dc[DC_IEN_BIT] && !dc[DC_SRST_BIT] && !hold;
  endfunction

endpackage

// File: rtl/pccfg_decode.sv
module pccfg_decode
  import pccfg_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int CFG_BASE = 'h200,
  parameter int TBL_LEN  = 8,
  localparam int IDX_W   = (TBL_LEN > 1) ? $clog2(TBL_LEN) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [IDX_W-1:0]  tbl_idx
);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(CFG_BASE);
  localparam logic [ADDR_W-1:0] TEND_A = ADDR_W'(TBL_LEN);

  logic [ADDR_W-1:0] offset;

  assign offset  = addr - BASE_A;
  assign tbl_idx = addr[IDX_W-1:0];

  always_comb begin
    sel = SEL_NONE;
    if (addr >= BASE_A) begin
      case (offset)
        ADDR_W'(0): sel = SEL_OPT;
        ADDR_W'(2): sel = SEL_STAT;
        ADDR_W'(4): sel = SEL_PINS;
        ADDR_W'(6): sel = SEL_SOCK;
        default:    sel = SEL_NONE;
      endcase
    end else if (addr < TEND_A) begin
      sel = SEL_TABLE;
    end
  end

endmodule

// File: rtl/pccfg_cis_rom.sv
module pccfg_cis_rom #(
  parameter int TBL_LEN = 8,
  parameter logic [8*TBL_LEN-1:0] TBL_DATA = '0,
  localparam int IDX_W = (TBL_LEN > 1) ? $clog2(TBL_LEN) : 1
) (
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       data
);

  logic [7:0] bytes [TBL_LEN];

  for (genvar g = 0; g < TBL_LEN; g++) begin : g_byte
    assign bytes[g] = TBL_DATA[8*g +: 8];
  end

  always_comb begin
    data = 8'h00;
    for (int i = 0; i < TBL_LEN; i++) begin
      if (idx == IDX_W'(i)) data = bytes[i];
    end
  end

endmodule

// File: rtl/pccfg_state.sv
module pccfg_state
  import pccfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  reg_sel_e   sel,
  input  logic [7:0] wr_data,
  input  logic       drive_irq,
  output logic [7:0] opt_q,
  output logic [7:0] stat_q,
  output logic [7:0] pins_q
);

  logic       wr_opt, wr_stat, wr_pins;
  logic       hold_next;
  logic [7:0] opt_n, stat_n, pins_n;

  assign wr_opt  = wr_en && (sel == SEL_OPT);
  assign wr_stat = wr_en && (sel == SEL_STAT);
  assign wr_pins = wr_en && (sel == SEL_PINS);

  assign hold_next = wr_opt ? wr_data[OPT_HOLD_BIT] : opt_q[OPT_HOLD_BIT];

  always_comb begin
    opt_n  = wr_opt ? opt_store(wr_data) : opt_q;
    stat_n = stat_q;
    pins_n = pins_q;
    if (wr_stat) begin
      stat_n = stat_merge(stat_q, wr_data);
      if (pwr_flip(stat_q, wr_data)) pins_n[PINS_RDY_BIT] = 1'b1;
    end
    if (wr_pins) pins_n = pins_merge(pins_q, wr_data);
    stat_n[STAT_IRQ_BIT] = drive_irq;
    if (hold_next) begin
      stat_n = '0;
      pins_n = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opt_q  <= '0;
      stat_q <= '0;
      pins_q <= '0;
    end else begin
      opt_q  <= opt_n;
      stat_q <= stat_n;
      pins_q <= pins_n;
    end
  end

  p_opt_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_opt |=> opt_q == ($past(wr_data) & 8'hCF));

  p_stat_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !opt_q[7]) |=>
      (stat_q[6:4] == $past(wr_data[6:4])) && (stat_q[2] == $past(wr_data[2])));

  p_ready_on_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !opt_q[7] && (wr_data[2] != stat_q[2])) |=> pins_q[5]);

  p_pin_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pins && !opt_q[7]) |=> pins_q[1] == $past(wr_data[1]));

  p_irq_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_next |=> stat_q[1] == $past(drive_irq));

  p_hold_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    opt_q[7] |-> (stat_q == 8'h00) && (pins_q == 8'h00));

endmodule

// File: rtl/pccfg_irq.sv
module pccfg_irq
  import pccfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       st_irq,
  input  logic [7:0] devctl,
  input  logic       hold,
  output logic       host_line
);

  logic unused_dc;
  assign unused_dc = ^{devctl[7:3], devctl[0]};

  assign host_line = line_level(st_irq, devctl, hold);

  p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (devctl[1] || devctl[2] || hold || st_irq) |-> !host_line);

  p_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!devctl[1] && !devctl[2] && !hold && !st_irq) |-> host_line);

endmodule

// File: rtl/pccfg_bank.sv
module pccfg_bank
  import pccfg_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int CFG_BASE = 'h200,
  parameter int TBL_LEN  = 8,
  parameter logic [8*TBL_LEN-1:0] TBL_DATA = 64'h01_DB_FF_03_00_1D_02_01,
  localparam int IDX_W   = (TBL_LEN > 1) ? $clog2(TBL_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              drive_irq,
  input  logic [7:0]        devctl,
  output logic              host_line,
  output logic [5:0]        card_mode,
  output logic              level_irq,
  output logic              card_reset,
  output logic              power_down,
  output logic              card_ready,
  output logic              mem_ready
);

  reg_sel_e         sel;
  logic [IDX_W-1:0] tbl_idx;
  logic [7:0]       tbl_byte;
  logic [7:0]       opt_q, stat_q, pins_q;

  pccfg_decode #(
    .ADDR_W  (ADDR_W),
    .CFG_BASE(CFG_BASE),
    .TBL_LEN (TBL_LEN)
  ) u_decode (
    .addr   (addr),
    .sel    (sel),
    .tbl_idx(tbl_idx)
  );

  pccfg_cis_rom #(
    .TBL_LEN (TBL_LEN),
    .TBL_DATA(TBL_DATA)
  ) u_rom (
    .idx (tbl_idx),
    .data(tbl_byte)
  );

  pccfg_state u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .sel      (sel),
    .wr_data  (wr_data),
    .drive_irq(drive_irq),
    .opt_q    (opt_q),
    .stat_q   (stat_q),
    .pins_q   (pins_q)
  );

  pccfg_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_irq   (stat_q[STAT_IRQ_BIT]),
    .devctl   (devctl),
    .hold     (opt_q[OPT_HOLD_BIT]),
    .host_line(host_line)
  );

  always_comb begin
    unique case (sel)
      SEL_TABLE: rd_data = tbl_byte;
      SEL_OPT:   rd_data = opt_q;
      SEL_STAT:  rd_data = stat_view(stat_q, devctl);
      SEL_PINS:  rd_data = pins_view(pins_q);
      default:   rd_data = 8'h00;
    endcase
  end

  assign card_mode  = opt_q[5:0];
  assign level_irq  = opt_q[6];
  assign card_reset = opt_q[OPT_HOLD_BIT];
  assign power_down = stat_q[STAT_PWR_BIT];
  assign card_ready = pins_q[PINS_RDY_BIT];
  assign mem_ready  = pins_q[PINS_MRD_BIT];

  p_sock_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_SOCK) |-> rd_data == 8'h00);

  p_stat_hide_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel == SEL_STAT) && devctl[1]) |-> !rd_data[1]);

  p_unknown_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> rd_data == 8'h00);

endmodule

// File: tb/test_pccfg_bank.sv
module test_pccfg_bank;

  localparam int AW   = 10;
  localparam int BASE = 'h200;
  localparam int TLEN = 10;
  localparam logic [8*TLEN-1:0] TDATA = 80'hA5_5A_3C_C3_77_18_DB_03_00_01;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_data = '0;
  logic          drive_irq = 1'b0;
  logic [7:0]    devctl = '0;
  logic [7:0]    rd_data;
  logic          host_line, level_irq, card_reset, power_down, card_ready, mem_ready;
  logic [5:0]    card_mode;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state
  int m_opt = 0, m_stat = 0, m_pins = 0;

  always #4 clk = ~clk;

  pccfg_bank #(.ADDR_W(AW), .CFG_BASE(BASE), .TBL_LEN(TLEN), .TBL_DATA(TDATA)) i_pccfg_bank (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .drive_irq(drive_irq), .devctl(devctl), .host_line(host_line),
    .card_mode(card_mode), .level_irq(level_irq), .card_reset(card_reset),
    .power_down(power_down), .card_ready(card_ready), .mem_ready(mem_ready));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int m_read(input int a, input int dc);
    if (a < BASE) return (a < TLEN) ? int'(TDATA[8*a +: 8]) : 0;
    case (a - BASE)
      0: return m_opt;
      2: return (dc & 2) ? (m_stat & 'hFD) : m_stat;
      4: return (m_pins & 'h20) + 12;
      default: return 0;
    endcase
  endfunction

  function automatic int m_line(input int dc);
    return ((m_stat & 2) == 0 && (dc & 6) == 0 && (m_opt & 'h80) == 0) ? 1 : 0;
  endfunction

  // behavioural model, advanced on every edge
  always @(posedge clk) begin
    int a, d, nopt, nstat, npins;
    a = int'(addr); d = int'(wr_data);
    if (!rst_n) begin
      m_opt = 0; m_stat = 0; m_pins = 0;
    end else begin
      nopt = m_opt; nstat = m_stat; npins = m_pins;
      if (wr_en && a == BASE) nopt = d & 'hCF;
      if (wr_en && a == BASE + 2) begin
        nstat = (m_stat & 'h80) | (d & 'h74);
        if (((m_stat ^ d) & 4) != 0) npins = npins | 'h20;
      end
      if (wr_en && a == BASE + 4) npins = (m_pins & 'h20) | (d & 2);
      nstat = (nstat & 'hFD) | (drive_irq ? 2 : 0);
      if ((nopt & 'h80) != 0) begin nstat = 0; npins = 0; end
      m_opt = nopt; m_stat = nstat; m_pins = npins;
    end
  end

  // compare on every clock, away from both edges
  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      chk("R2 read path", int'(rd_data), m_read(int'(addr), int'(devctl)));
      chk("R9 host_line", int'(host_line), m_line(int'(devctl)));
      chk("R3 card_mode", int'({level_irq, card_mode}), m_opt & 'h7F);
      chk("R12 card_reset", int'(card_reset), (m_opt >> 7) & 1);
      chk("R4 power_down", int'(power_down), (m_stat >> 2) & 1);
      chk("R5 card_ready", int'(card_ready), (m_pins >> 5) & 1);
      chk("R7 mem_ready", int'(mem_ready), (m_pins >> 1) & 1);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = AW'(a); wr_data = 8'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string tag, input int a, input int exp);
    @(negedge clk);
    addr = AW'(a); wr_en = 1'b0;
    #1 chk(tag, int'(rd_data), exp);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd("R1 option after reset", BASE, 0);
    rd("R1 status after reset", BASE + 2, 0);
    rd("R1 pins after reset", BASE + 4, 'h0C);
    chk("R1 mode after reset", int'(card_mode), 0);
    chk("R1 ready after reset", int'({card_ready, mem_ready, power_down}), 0);
    // R2 table and past its end
    for (int i = 0; i < TLEN + 3; i++)
      rd("R2 table byte", i, (i < TLEN) ? int'(TDATA[8*i +: 8]) : 0);
    rd("R2 below base far", BASE - 1, 0);
    // R3 option masking
    wr(BASE, 'h7D);
    rd("R3 option readback", BASE, 'h4D);
    chk("R3 mode field", int'(card_mode), 'h0D);
    chk("R3 level bit", int'(level_irq), 1);
    wr(BASE, 'h33);
    rd("R3 option readback 2", BASE, 'h03);
    // R4 and R5 status write, flip sets ready
    wr(BASE + 2, 'hFF);
    rd("R4 status load", BASE + 2, 'h74);
    chk("R5 ready after flip", int'(card_ready), 1);
    chk("R4 power_down out", int'(power_down), 1);
    wr(BASE + 4, 'h00);
    wr(BASE + 2, 'h04);
    rd("R4 status reload", BASE + 2, 'h04);
    rd("R5 ready kept", BASE + 4, 'h2C);
    // R10 irq follows drive, R6 view masking, R9 gates
    @(negedge clk); drive_irq = 1'b1;
    rd("R10 irq visible", BASE + 2, 'h06);
    chk("R9 line low with irq", int'(host_line), 0);
    @(negedge clk); devctl = 8'h02;
    rd("R6 irq hidden", BASE + 2, 'h04);
    @(negedge clk); drive_irq = 1'b0; devctl = 8'h00;
    @(negedge clk);
    chk("R9 line high open", int'(host_line), 1);
    devctl = 8'h04; #1 chk("R9 gate srst", int'(host_line), 0);
    devctl = 8'h02; #1 chk("R9 gate ien", int'(host_line), 0);
    devctl = 8'hF9; #1 chk("R9 other bits", int'(host_line), 1);
    devctl = 8'h00;
    // R7 pins
    wr(BASE + 4, 'hFF);
    rd("R7 pin read", BASE + 4, 'h2C);
    chk("R7 mem_ready set", int'(mem_ready), 1);
    wr(BASE + 4, 'h00);
    chk("R7 mem_ready clear", int'(mem_ready), 0);
    chk("R7 ready kept", int'(card_ready), 1);
    // R8 socket, R11 unknown
    wr(BASE + 6, 'hFF);
    rd("R8 socket zero", BASE + 6, 0);
    wr(BASE + 1, 'hFF); wr(BASE + 8, 'hFF); wr(3, 'hFF);
    rd("R11 unknown read", BASE + 1, 0);
    rd("R11 option intact", BASE, 'h03);
    rd("R11 status intact", BASE + 2, 'h04);
    rd("R11 table intact", 3, int'(TDATA[8*3 +: 8]));
    // R12 soft reset hold
    wr(BASE, 'hB1);
    chk("R12 hold out", int'(card_reset), 1);
    chk("R12 mode kept", int'(card_mode), 'h01);
    drive_irq = 1'b1;
    wr(BASE + 2, 'h74);
    rd("R12 status held", BASE + 2, 0);
    rd("R12 pins held", BASE + 4, 'h0C);
    chk("R12 line low", int'(host_line), 0);
    wr(BASE, 'h01);
    rd("R12 released", BASE + 2, 'h02);
    drive_irq = 1'b0;
    // mixed traffic against the model
    begin
      int lfsr = 'h1ACE;
      for (int k = 0; k < 400; k++) begin
        @(negedge clk);
        lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 'hFFFF;
        addr = AW'((lfsr & 8) != 0 ? BASE + (lfsr & 7) : (lfsr >> 4) & 15);
        wr_en = (lfsr >> 3) & 1;
        wr_data = 8'((lfsr >> 8) & ((lfsr & 'h40) != 0 ? 'hFF : 'h7F));
        drive_irq = (lfsr >> 5) & 1;
        devctl = 8'((lfsr >> 9) & 6);
      end
      @(negedge clk); wr_en = 1'b0;
    end
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule